// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a parameterized number of external interrupt inputs into one interrupt request for a host processor. Each input is first brought into the system clock domain through a two-stage synchronizer. Every line then has its own sense selection: it can respond to a level or to an edge. For a level line the active level can be high or low. For an edge line the active edge can be rising or falling. Detected events are held in a status register, and that register is visible whether or not the line is enabled.

A per-line enable mask gates the status bits. The mask is changed only through separate set and clear write registers, so software never needs a read-modify-write to change it. The combined request output is the registered OR of all status bits that are enabled. Register bits for lines that are not built always read as zero. Software can write all ones to the sense-mode register, read it back, and take the highest set bit as the number of implemented lines.

The host reaches the registers through a plain word-indexed bus. The bus has an address, a write strobe, write data, and a read data path that answers in the same cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and `irq_out` is low. All lines are therefore masked and set to falling-edge sense.
- R2: Register index 0 holds the sense mode, where 1 means level and 0 means edge. Index 1 holds the edge polarity, where 1 means rising and 0 means falling. Index 2 holds the level polarity, where 1 means active-high and 0 means active-low. Each reads back the written value on its low NUM_LINES bits. All bits at and above NUM_LINES read as zero at every index.
- R3: Writing index 3 (enable-set) unmasks each line whose data bit is 1. Bits written as 0 leave the mask unchanged. Index 5 reads back the current mask.
- R4: Writing index 4 (enable-clear) masks each line whose data bit is 1. Bits written as 0 leave the mask unchanged.
- R5: On an edge line with edge polarity 1, a 0-to-1 input transition sets the line's status bit. A 1-to-0 transition does not set it.
- R6: On an edge line with edge polarity 0, a 1-to-0 input transition sets the line's status bit. A 0-to-1 transition does not set it.
- R7: Writing index 7 (clear) with a bit set to 1 clears a latched edge status bit. Bits written as 0 have no effect. Index 6 reads the status bits.
- R8: On a level line, the status bit follows the active level of the synchronized input. A clear write does not remove the bit while the level stays active.
- R9: Status bits record events on masked lines too. `irq_out` is the registered OR of status AND mask, so it stays low when every set status bit is masked.
- R10: Indexes 3, 4 and 7 are write-only and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | NUM_LINES | External interrupt lines, asynchronous to clk |
| bus_addr | input | ADDR_W | Register word index |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current bus_addr, available in the same cycle |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
The detection path is driven with four input patterns. A rising and a falling transition are each applied to lines set for the opposite edge, which separates the polarity decode from plain change detection. A level line is held active through a clear write, which separates level-following status from a latch. An active-low line is driven both ways, which shows that the level polarity is decoded and not always read as high. Events are also raised on a masked line, which separates the status register from the gated request output. Mask writes that mix 1 and 0 bits show that the set and clear registers touch only the bits written as 1.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // Register word indexes on the host bus
  localparam int unsigned IDX_SENSE   = 0;
  localparam int unsigned IDX_EDGEPOL = 1;
  localparam int unsigned IDX_LVLPOL  = 2;
  localparam int unsigned IDX_EN_SET  = 3;
  localparam int unsigned IDX_EN_CLR  = 4;
  localparam int unsigned IDX_MASK    = 5;
  localparam int unsigned IDX_STATUS  = 6;
  localparam int unsigned IDX_CLEAR   = 7;
  localparam int unsigned IDX_COUNT   = 8;
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] meta_q;
  logic [N-1:0] cur_q;
  logic [N-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) begin
          meta_q[g] <= 1'b0;
          cur_q[g]  <= 1'b0;
          prev_q[g] <= 1'b0;
        end else begin
          meta_q[g] <= async_in[g];
          cur_q[g]  <= meta_q[g];
          prev_q[g] <= cur_q[g];
        end
      end
    end
  endgenerate

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      sense_q,
  output logic [N-1:0]      edgepol_q,
  output logic [N-1:0]      lvlpol_q,
  output logic [N-1:0]      mask_q
);
  import eic_pkg::*;

  logic [N-1:0] sense_d, edgepol_d, lvlpol_d, mask_d;
  logic         hit_sense, hit_edge, hit_lvl, hit_set, hit_clr;

  always_comb begin
    hit_sense = wr && (addr == ADDR_W'(IDX_SENSE));
    hit_edge  = wr && (addr == ADDR_W'(IDX_EDGEPOL));
    hit_lvl   = wr && (addr == ADDR_W'(IDX_LVLPOL));
    hit_set   = wr && (addr == ADDR_W'(IDX_EN_SET));
    hit_clr   = wr && (addr == ADDR_W'(IDX_EN_CLR));

    sense_d   = hit_sense ? wdata : sense_q;
    edgepol_d = hit_edge  ? wdata : edgepol_q;
    lvlpol_d  = hit_lvl   ? wdata : lvlpol_q;

    mask_d = mask_q;
    if (hit_set) mask_d = mask_q | wdata;
    if (hit_clr) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sense_q   <= '0;
      edgepol_q <= '0;
      lvlpol_q  <= '0;
      mask_q    <= '0;
    end else begin
      sense_q   <= sense_d;
      edgepol_q <= edgepol_d;
      lvlpol_q  <= lvlpol_d;
      mask_q    <= mask_d;
    end
  end
endmodule

// File: rtl/eic_detect.sv
module eic_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] edgepol,
  input  logic [N-1:0] lvlpol,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status_q
);
  logic [N-1:0] status_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic rise, fall, edge_hit, lvl_act;
      always_comb begin
        rise     = cur[g] & ~prev[g];
        fall     = ~cur[g] & prev[g];
        edge_hit = edgepol[g] ? rise : fall;
        lvl_act  = lvlpol[g] ? cur[g] : ~cur[g];
        if (sense[g]) status_d[g] = lvl_act;
        else          status_d[g] = edge_hit | (status_q[g] & ~clr[g]);
      end

      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) status_q[g] <= 1'b0;
        else         status_q[g] <= status_d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_out
);
  import eic_pkg::*;

  localparam int unsigned N = NUM_LINES;

  logic         rst_sn;
  logic [N-1:0] wdata_lines;
  logic [N-1:0] cur, prev;
  logic [N-1:0] sense_q, edgepol_q, lvlpol_q, mask_q;
  logic [N-1:0] status_q;
  logic [N-1:0] clr_vec;
  logic [N-1:0] rd_lines;
  logic         irq_d, irq_q;

  assign wdata_lines = bus_wdata[N-1:0];

  generate
    if (N < DATA_W) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:N];
    end
  endgenerate

  eic_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  eic_sync #(.N(N)) u_sync (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .async_in (irq_in),
    .cur      (cur),
    .prev     (prev)
  );

  eic_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (wdata_lines),
    .sense_q   (sense_q),
    .edgepol_q (edgepol_q),
    .lvlpol_q  (lvlpol_q),
    .mask_q    (mask_q)
  );

  always_comb begin
    clr_vec = (bus_wr && (bus_addr == ADDR_W'(IDX_CLEAR))) ? wdata_lines : '0;
  end

  eic_detect #(.N(N)) u_det (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .cur      (cur),
    .prev     (prev),
    .sense    (sense_q),
    .edgepol  (edgepol_q),
    .lvlpol   (lvlpol_q),
    .clr      (clr_vec),
    .status_q (status_q)
  );

  // Read path: unimplemented bits are zero through zero-extension
  always_comb begin
    unique case (bus_addr)
      ADDR_W'(IDX_SENSE):   rd_lines = sense_q;
      ADDR_W'(IDX_EDGEPOL): rd_lines = edgepol_q;
      ADDR_W'(IDX_LVLPOL):  rd_lines = lvlpol_q;
      ADDR_W'(IDX_MASK):    rd_lines = mask_q;
      ADDR_W'(IDX_STATUS):  rd_lines = status_q;
      default:              rd_lines = '0;
    endcase
    bus_rdata = DATA_W'(rd_lines);
  end

  // Combined request, registered
  always_comb begin
    irq_d = |(status_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int unsigned N      = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      status_q,
  input logic              irq_out
);
  import eic_pkg::*;

  logic is_set, is_clr;
  assign is_set = bus_wr && (bus_addr == ADDR_W'(IDX_EN_SET));
  assign is_clr = bus_wr && (bus_addr == ADDR_W'(IDX_EN_CLR));

  a_r3_set_unmasks: assert property (@(posedge clk) disable iff (!rst_sn)
    is_set |=> ((mask_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

  a_r3_set_keeps_zero_bits: assert property (@(posedge clk) disable iff (!rst_sn)
    is_set |=> ((mask_q & ~$past(bus_wdata[N-1:0])) == ($past(mask_q) & ~$past(bus_wdata[N-1:0]))));

  a_r4_clr_masks: assert property (@(posedge clk) disable iff (!rst_sn)
    is_clr |=> ((mask_q & $past(bus_wdata[N-1:0])) == '0));

  a_r4_mask_stable: assert property (@(posedge clk) disable iff (!rst_sn)
    (!is_set && !is_clr) |=> $stable(mask_q));

  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_sn)
    ((status_q & mask_q) != '0) |=> irq_out);

  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_sn)
    ((status_q & mask_q) == '0) |=> !irq_out);

  generate
    if (N < DW) begin : g_hi
      a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_sn)
        bus_rdata[DW-1:N] == '0);
    end
  endgenerate
endmodule

bind ext_irq_ctrl eic_checker #(.N(NUM_LINES), .DW(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .irq_out   (irq_out)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq_out;

  int n_checks = 0;
  int n_fails  = 0;

  ext_irq_ctrl #(.NUM_LINES(N), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1 reset value", v, '0);
    end
    check("R1 irq_out after reset", {31'b0, irq_out}, 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] v;
    int top;
    wr(0, 32'hFFFF_FFFF);
    rd(0, v);
    check("R2 sense all ones", v, 32'h0000_00FF);
    top = 0;
    for (int b = 0; b < DW; b++) if (v[b]) top = b + 1;
    check("R2 line count discovery", top, N);
    wr(0, 32'h0);
    wr(1, 32'hA5A5_5AC3);
    rd(1, v);
    check("R2 edge polarity readback", v, 32'h0000_00C3);
    wr(1, 32'h0);
    wr(2, 32'h1234_5666);
    rd(2, v);
    check("R2 level polarity readback", v, 32'h0000_0066);
    wr(2, 32'h0);
    for (int a = 3; a < 8; a += (a == 4) ? 3 : 1) begin
      wr(a, 32'h0);
      rd(a, v);
      if (a != 5 && a != 6) check("R10 write-only reads zero", v, 32'h0);
    end
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wr(3, 32'h05); rd(5, v); check("R3 enable-set", v, 32'h05);
    wr(3, 32'h00); rd(5, v); check("R3 zero bits no effect", v, 32'h05);
    wr(3, 32'h80); rd(5, v); check("R3 enable-set accumulates", v, 32'h85);
    wr(4, 32'h04); rd(5, v); check("R4 enable-clear", v, 32'h81);
    wr(4, 32'h00); rd(5, v); check("R4 zero bits no effect", v, 32'h81);
    wr(4, 32'hFF); rd(5, v); check("R4 clear all", v, 32'h00);
  endtask

  task automatic t_edge_fall();
    logic [DW-1:0] v;
    wr(7, 32'hFF);
    irq_in[0] = 1'b1; settle();
    rd(6, v); check("R6 rising ignored on falling line", v, 32'h00);
    irq_in[0] = 1'b0; settle();
    rd(6, v); check("R6 falling edge latched", v, 32'h01);
    check("R9 masked line keeps irq_out low", {31'b0, irq_out}, 0);
  endtask

  task automatic t_clear();
    logic [DW-1:0] v;
    wr(7, 32'h00); rd(6, v); check("R7 zero clear bits no effect", v, 32'h01);
    wr(7, 32'h01); rd(6, v); check("R7 clear removes edge status", v, 32'h00);
  endtask

  task automatic t_edge_rise();
    logic [DW-1:0] v;
    wr(1, 32'h02);
    irq_in[1] = 1'b1; settle();
    rd(6, v); check("R5 rising edge latched", v, 32'h02);
    wr(7, 32'h02);
    irq_in[1] = 1'b0; settle();
    rd(6, v); check("R5 falling ignored on rising line", v, 32'h00);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    wr(3, 32'h02);
    check("R9 irq_out low with no status", {31'b0, irq_out}, 0);
    irq_in[1] = 1'b1; settle();
    check("R9 irq_out on enabled event", {31'b0, irq_out}, 1);
    wr(4, 32'h02);
    @(negedge clk);
    check("R9 irq_out drops when masked", {31'b0, irq_out}, 0);
    rd(6, v); check("R9 status kept while masked", v, 32'h02);
    wr(3, 32'h02); @(negedge clk);
    check("R9 irq_out back on unmask", {31'b0, irq_out}, 1);
    wr(7, 32'h02); @(negedge clk);
    check("R7 irq_out drops after clear", {31'b0, irq_out}, 0);
    wr(4, 32'hFF);
  endtask

  task automatic t_level();
    logic [DW-1:0] v;
    irq_in[3] = 1'b1;
    settle();
    wr(7, 32'hFF);
    wr(2, 32'h04);
    wr(0, 32'h0C);
    settle();
    rd(6, v); check("R8 inactive levels give no status", v, 32'h00);
    irq_in[2] = 1'b1; settle();
    rd(6, v); check("R8 active-high level sets status", v, 32'h04);
    wr(7, 32'h04); rd(6, v);
    check("R8 clear ignored while level active", v, 32'h04);
    wr(3, 32'h04); @(negedge clk);
    check("R9 irq_out follows level line", {31'b0, irq_out}, 1);
    irq_in[2] = 1'b0; settle();
    rd(6, v); check("R8 status follows level away", v, 32'h00);
    check("R9 irq_out drops with level", {31'b0, irq_out}, 0);
    irq_in[3] = 1'b0; settle();
    rd(6, v); check("R8 active-low level sets status", v, 32'h08);
    irq_in[3] = 1'b1; settle();
    rd(6, v); check("R8 active-low released", v, 32'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_mask();
    t_edge_fall();
    t_clear();
    t_edge_rise();
    t_irq();
    t_level();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule